// File: doc/BRIEF.md
# Five-Pin General-Purpose I/O Port

This block is a small memory-mapped I/O port with five usable pins. Software reaches three registers over a simple single-cycle register bus: a direction register that makes each pin an input or an output, an output data register, and a read-only pin-state register. The block drives one output enable and one output value per pin. Pin levels pass through a two-flop synchronizer before anything reads them.

Reading the pin-state register returns the latched output value on pins configured as outputs and the synchronized pin level on pins configured as inputs. A power-on reset and hardware standby clear both writable registers. A manual reset and software standby keep their contents and block writes.

When the external-bus mode input is high, pins 0 to 3 carry chip-select outputs on any pin whose direction bit is 1. Pin 4 carries a column-address-strobe output when the DRAM enable input is also high. For a pin taken over this way, the output value comes from a per-pin alternate-function input and the output enable is forced high.

Top module: `gpio5_port`

## Requirements
- R1: While `rst_ni` is low, the direction and data registers are 0, so all pins are inputs (`pin_oe_o` = 0). After reset, reads of all three registers return 0 while the pins are low.
- R2: A write with `reg_addr_i` = 0 loads the direction register and a write with `reg_addr_i` = 1 loads the data register, from `reg_wdata_i[4:0]`. Reading either address returns the register in bits 4:0. Bits 7:5 read 0 and writes to them are ignored.
- R3: While `hw_stby_i` is high, both registers are cleared at every clock edge and bus writes are ignored.
- R4: While `man_rst_i` or `sw_stby_i` is high (and `hw_stby_i` is low), both registers keep their contents and bus writes are ignored.
- R5: A write with `reg_addr_i` = 2 (pin-state register) changes neither register and no pin output.
- R6: A read with `reg_addr_i` = 2 returns, for each bit 4:0, the data register bit where the direction bit is 1 and the synchronized pin level where the direction bit is 0. Bits 7:5 read 0. Address 3 reads 0.
- R7: A change on `pin_i` shows up in the pin-state read after exactly two rising clock edges.
- R8: With `mode_ext_i` low, `pin_oe_o` equals the direction register and `pin_o` equals the data register for all five pins. `dram_en_i` has no effect.
- R9: With `mode_ext_i` high, each pin 0..3 whose direction bit is 1 has its output enable high and its output taken from `alt_i`. Each pin 0..3 whose direction bit is 0 has its output enable low.
- R10: With `mode_ext_i` and `dram_en_i` both high, pin 4 has its output enable high and its output taken from `alt_i[4]`, whatever its direction bit. Otherwise pin 4 follows its direction and data bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| man_rst_i | input | 1 | Manual reset; registers held |
| sw_stby_i | input | 1 | Software standby; registers held |
| hw_stby_i | input | 1 | Hardware standby; registers cleared |
| mode_ext_i | input | 1 | External-bus mode; enables the alternate pin functions |
| dram_en_i | input | 1 | DRAM interface on; pin 4 carries the strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 direction, 1 data, 2 pin state |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` (combinational) |
| alt_i | input | 5 | Alternate-function output values (chip selects 0..3, strobe 4) |
| pin_i | input | 5 | Pin input levels |
| pin_o | output | 5 | Pin output values |
| pin_oe_o | output | 5 | Pin output enables |

## Verification
The pin-state read is tested with all pins as outputs, all pins as inputs, and a mixed direction pattern. In each case the data register and the pin levels are set to differ, so the read shows which source each bit came from. The synchronizer is probed one and two edges after a pin change, which tells a two-stage delay from a shorter or longer one. The pin mux is run in single-chip mode, in external mode with DRAM off and two different direction patterns, in external mode with DRAM on, and in single-chip mode with DRAM on. Together these separate the chip-select takeover, the strobe takeover and plain I/O.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
  localparam int N_PINS  = 5;
  localparam int N_CS    = 4;
  localparam int DW      = 8;
  localparam int AW      = 2;

  typedef enum logic [AW-1:0] {
    ADDR_DIR  = 2'd0,
    ADDR_DATA = 2'd1,
    ADDR_PIN  = 2'd2,
    ADDR_NONE = 2'd3
  } gpio_addr_e;
endpackage

// File: rtl/gpio5_sync.sv
module gpio5_sync #(
  parameter int WIDTH  = 5,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      logic [1:0] age_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
      end
      // R7: output is the input from two edges ago
      assert_sync_lat_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (age_q == 2'd2) |-> (q_o == $past(d_i, 2)));
    end
  endgenerate
endmodule

// File: rtl/gpio5_regs.sv
module gpio5_regs
  import gpio5_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hw_stby_i,
  input  logic              hold_i,
  input  logic              we_i,
  input  gpio_addr_e        addr_i,
  input  logic [N_PINS-1:0] wdata_i,
  output logic [N_PINS-1:0] dir_o,
  output logic [N_PINS-1:0] data_o
);
  logic [N_PINS-1:0] dir_q, data_q;
  logic              wr_ok;

  assign wr_ok = we_i && !hold_i && !hw_stby_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (hw_stby_i) begin
      dir_q  <= '0;
      data_q <= '0;
    end else if (wr_ok) begin
      unique case (addr_i)
        ADDR_DIR:  dir_q  <= wdata_i;
        ADDR_DATA: data_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign dir_o  = dir_q;
  assign data_o = data_q;

  assert_hw_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> (dir_q == '0) && (data_q == '0));
  assert_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_i && !hw_stby_i) |=> $stable(dir_q) && $stable(data_q));
  assert_pin_wr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == ADDR_PIN && !hw_stby_i) |=> $stable(dir_q) && $stable(data_q));
  assert_data_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_ok && addr_i == ADDR_DATA) |=> (data_q == $past(wdata_i)));
endmodule

// File: rtl/gpio5_pinmux.sv
module gpio5_pinmux
  import gpio5_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_ext_i,
  input  logic              dram_en_i,
  input  logic [N_PINS-1:0] dir_i,
  input  logic [N_PINS-1:0] data_i,
  input  logic [N_PINS-1:0] alt_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o
);
  localparam int CAS_IDX = N_PINS - 1;

  logic [N_PINS-1:0] take_alt;

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    if (i < N_CS) begin : g_cs
      assign take_alt[i] = mode_ext_i & dir_i[i];
    end else if (i == CAS_IDX) begin : g_cas
      assign take_alt[i] = mode_ext_i & dram_en_i;
    end else begin : g_plain
      assign take_alt[i] = 1'b0;
    end
    assign pin_oe_o[i] = take_alt[i] | dir_i[i];
    assign pin_o[i]    = take_alt[i] ? alt_i[i] : data_i[i];
  end

  assert_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_ext_i |-> (pin_oe_o == dir_i) && (pin_o == data_i));
  assert_cs_oe_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_ext_i |-> (pin_oe_o[N_CS-1:0] == dir_i[N_CS-1:0]));
  assert_cas_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_ext_i && dram_en_i) |-> pin_oe_o[CAS_IDX] && (pin_o[CAS_IDX] == alt_i[CAS_IDX]));
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
  import gpio5_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              man_rst_i,
  input  logic              sw_stby_i,
  input  logic              hw_stby_i,
  input  logic              mode_ext_i,
  input  logic              dram_en_i,
  input  logic              reg_we_i,
  input  logic [AW-1:0]     reg_addr_i,
  input  logic [DW-1:0]     reg_wdata_i,
  output logic [DW-1:0]     reg_rdata_o,
  input  logic [N_PINS-1:0] alt_i,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] pin_o,
  output logic [N_PINS-1:0] pin_oe_o
);
  gpio_addr_e        addr;
  logic [N_PINS-1:0] dir, data, pin_sync, pin_view;
  logic              unused_wdata;

  assign addr         = gpio_addr_e'(reg_addr_i);
  assign unused_wdata = ^reg_wdata_i[DW-1:N_PINS];

  gpio5_regs i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .hw_stby_i (hw_stby_i),
    .hold_i    (man_rst_i | sw_stby_i),
    .we_i      (reg_we_i),
    .addr_i    (addr),
    .wdata_i   (reg_wdata_i[N_PINS-1:0]),
    .dir_o     (dir),
    .data_o    (data)
  );

  gpio5_sync #(.WIDTH(N_PINS), .STAGES(2)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pin_i),
    .q_o    (pin_sync)
  );

  gpio5_pinmux i_mux (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_ext_i (mode_ext_i),
    .dram_en_i  (dram_en_i),
    .dir_i      (dir),
    .data_i     (data),
    .alt_i      (alt_i),
    .pin_o      (pin_o),
    .pin_oe_o   (pin_oe_o)
  );

  assign pin_view = (dir & data) | (~dir & pin_sync);

  always_comb begin
    reg_rdata_o = '0;
    unique case (addr)
      ADDR_DIR:  reg_rdata_o[N_PINS-1:0] = dir;
      ADDR_DATA: reg_rdata_o[N_PINS-1:0] = data;
      ADDR_PIN:  reg_rdata_o[N_PINS-1:0] = pin_view;
      default:   reg_rdata_o = '0;
    endcase
  end

  assert_rsv_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rdata_o[DW-1:N_PINS] == '0);
  assert_out_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr == ADDR_PIN) |-> ((reg_rdata_o[N_PINS-1:0] & dir) == (data & dir)));
endmodule

// File: tb/test_gpio5_port.sv
`timescale 1ns/1ps
module test_gpio5_port;
  logic       clk = 0, rst_ni = 0;
  logic       man_rst = 0, sw_stby = 0, hw_stby = 0, mode_ext = 0, dram_en = 0;
  logic       we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic [4:0] alt = 0, pin_in = 0, pin_out, pin_oe;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  gpio5_port i_gpio5_port (
    .clk_i(clk), .rst_ni(rst_ni), .man_rst_i(man_rst), .sw_stby_i(sw_stby),
    .hw_stby_i(hw_stby), .mode_ext_i(mode_ext), .dram_en_i(dram_en),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .alt_i(alt), .pin_i(pin_in), .pin_o(pin_out), .pin_oe_o(pin_oe)
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    chk("R1 oe in reset", {3'b0, pin_oe}, 8'h00);
    @(negedge clk); rst_ni = 1;
    rd(0, v); chk("R1 dir", v, 8'h00);
    rd(1, v); chk("R1 data", v, 8'h00);
    rd(2, v); chk("R1 pin", v, 8'h00);
  endtask

  task automatic t_rw;
    logic [7:0] v;
    wr(0, 8'hFF); rd(0, v); chk("R2 dir reserved", v, 8'h1F);
    wr(1, 8'hEA); rd(1, v); chk("R2 data reserved", v, 8'h0A);
    rd(3, v); chk("R6 addr3", v, 8'h00);
  endtask

  task automatic t_single;
    logic [7:0] v;
    mode_ext = 0; dram_en = 1; pin_in = 5'h0A; alt = 5'h1F;
    wr(0, 8'h1F); wr(1, 8'h15);
    repeat (3) @(negedge clk);
    chk("R8 oe", {3'b0, pin_oe}, 8'h1F);
    chk("R8 out", {3'b0, pin_out}, 8'h15);
    rd(2, v); chk("R6 all outputs", v, 8'h15);
    wr(0, 8'h00); rd(2, v); chk("R6 all inputs", v, 8'h0A);
    chk("R8 dram ignored", {3'b0, pin_oe}, 8'h00);
    dram_en = 0;
  endtask

  task automatic t_mixed;
    logic [7:0] v;
    pin_in = 5'h14; wr(0, 8'h03); wr(1, 8'h1F);
    repeat (3) @(negedge clk);
    rd(2, v); chk("R6 mixed", v, 8'h17);
  endtask

  task automatic t_sync;
    logic [7:0] v;
    wr(0, 8'h00); pin_in = 5'h00; addr = 2;
    repeat (3) @(negedge clk);
    pin_in = 5'h1F;
    @(posedge clk); #1 v = rdata; chk("R7 one edge", v, 8'h00);
    @(posedge clk); #1 v = rdata; chk("R7 two edges", v, 8'h1F);
  endtask

  task automatic t_pinwr;
    logic [7:0] v;
    wr(0, 8'h0C); wr(1, 8'h09);
    wr(2, 8'hFF);
    rd(0, v); chk("R5 dir kept", v, 8'h0C);
    rd(1, v); chk("R5 data kept", v, 8'h09);
    chk("R5 out kept", {3'b0, pin_out}, 8'h09);
  endtask

  task automatic t_hold;
    logic [7:0] v;
    @(negedge clk); man_rst = 1;
    wr(1, 8'h1F); wr(0, 8'h1F);
    @(negedge clk); man_rst = 0;
    rd(1, v); chk("R4 manual data", v, 8'h09);
    rd(0, v); chk("R4 manual dir", v, 8'h0C);
    @(negedge clk); sw_stby = 1;
    wr(1, 8'h00); wr(0, 8'h00);
    @(negedge clk); sw_stby = 0;
    rd(1, v); chk("R4 sw stby data", v, 8'h09);
    rd(0, v); chk("R4 sw stby dir", v, 8'h0C);
  endtask

  task automatic t_hws;
    logic [7:0] v;
    @(negedge clk); hw_stby = 1;
    wr(1, 8'h1F);
    @(negedge clk); hw_stby = 0;
    rd(1, v); chk("R3 data cleared", v, 8'h00);
    rd(0, v); chk("R3 dir cleared", v, 8'h00);
  endtask

  task automatic t_ext;
    mode_ext = 1; dram_en = 0; alt = 5'h1F;
    wr(1, 8'h00); wr(0, 8'h05);
    chk("R9 cs oe", {3'b0, pin_oe}, 8'h05);
    chk("R9 cs out", {3'b0, pin_out & pin_oe}, 8'h05);
    alt = 5'h00; wr(1, 8'h1F); wr(0, 8'h1A);
    chk("R9 cs oe 2", {3'b0, pin_oe}, 8'h1A);
    chk("R9 cs out 2", {3'b0, pin_out & pin_oe}, 8'h10);
    alt = 5'h10; wr(1, 8'h00); wr(0, 8'h00); dram_en = 1;
    #1;
    chk("R10 cas oe", {3'b0, pin_oe}, 8'h10);
    chk("R10 cas out", {3'b0, pin_out & pin_oe}, 8'h10);
    mode_ext = 0; #1;
    chk("R10 cas off in single", {3'b0, pin_oe}, 8'h00);
    dram_en = 0;
  endtask

  task automatic t_por;
    logic [7:0] v;
    wr(0, 8'h11); wr(1, 8'h11);
    @(negedge clk); rst_ni = 0;
    @(negedge clk); rst_ni = 1;
    rd(0, v); chk("R1 por dir", v, 8'h00);
    rd(1, v); chk("R1 por data", v, 8'h00);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_rw();
    t_single();
    t_mixed();
    t_sync();
    t_pinwr();
    t_hold();
    t_hws();
    t_ext();
    t_por();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule